// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer that runs interrupt entry and the return-from-interrupt instruction for a 16-bit processor with 24-bit addresses. Seven numbered request lines come in. While interrupts are enabled, a request is accepted at once. The sequencer then waits until the instruction in flight completes. After that it saves the whole register context to the stack, one 16-bit word per cycle, and asks the datapath to load the program counter from the vector of the accepted request. The flag register is cleared in the same cycle. While a handler runs, interrupts are disabled. A request that arrives in that time is remembered as a pending vector number, and the highest number seen is kept.

On return, the sequencer checks the pending number. If nothing is pending, it pops the saved context in the exact reverse of the push order and then re-enables interrupts. If a request is pending, it skips the stack entirely and loads the program counter straight from the pending vector. The saved context is still on the stack, so the chained handler returns through the same frame. Vector 0 (reset) never passes through this block. The datapath and the vector table are outside the block. The sequencer only drives push/pop strobes, a word selector, a vector number and the load strobes.

Top module: `irq_seq`

## Requirements
- R1: After an accepted request, no push occurs until `instr_done` is seen. This can be in the accepting cycle or in any later cycle.
- R2: Entry pushes 13 words in 13 consecutive cycles with `word_sel` counting 0 to 12. The codes are: 0..7 for R0..R7, 8 for flags, 9 for PC high word, 10 for PC low word, 11 for Z high word, 12 for Z low word.
- R3: In the cycle after the last push, `pc_load` and `flags_clr` are both high for one cycle, with `vec_num` equal to the accepted request number.
- R4: `ie` is 0 from the cycle after a request is accepted until the return sequence completes without anything pending. No push or pop ever happens while `ie` is 1.
- R5: Line n of `irq_req` is bit n (bits 1 to 7). When several lines are high in the accepting cycle, the highest number is served.
- R6: While `ie` is 0, incoming requests are held as a pending 3-bit number (0 means none). A later request replaces it only if its number is higher.
- R7: A return with nothing pending pops 13 words in consecutive cycles with `word_sel` going 12 down to 0. `ie` returns to 1 in the cycle after the last pop.
- R8: A return with a request pending performs no push or pop. In the next cycle it raises `pc_load` with `flags_clr` low and `vec_num` equal to the pending number, and it clears the pending number.
- R9: A request that arrives during a push or pop sequence is not lost. If one is pending when the last pop ends, `ie` stays 0. A full new entry for it then starts at the next `instr_done`.
- R10: After reset, `ie` is 1 and `push_req`, `pop_req`, `pc_load` and `flags_clr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 7 | Request lines 1..7 (bit n is line n), one-cycle pulses |
| instr_done | input | 1 | Strobe: current instruction has completed |
| reti | input | 1 | Strobe: return-from-interrupt instruction is executing |
| ie | output | 1 | Interrupt enable flag |
| push_req | output | 1 | Push the word selected by `word_sel` |
| pop_req | output | 1 | Pop into the word selected by `word_sel` |
| word_sel | output | 4 | Context word selector (codes in R2) |
| pc_load | output | 1 | Load the PC from vector `vec_num` |
| flags_clr | output | 1 | Clear the flag register (entry only) |
| vec_num | output | 3 | Vector number to load |

## Verification
The first pattern is a single request held back by a late `instr_done`. It separates waiting for the instruction boundary from starting the push at once. The bench also sends several requests together and staggered ones in falling and rising order while the handler runs. These show whether the highest number is picked, and whether a lower later request is wrongly allowed to overwrite the pending number. Returns are tried both with and without a pending request, which separates the chained path with no stack traffic from the full unstacking. Requests injected during the push and the pop bursts show whether a request arriving mid-sequence is kept or dropped.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int NUM_GPR   = 8;
    localparam int CTX_WORDS = NUM_GPR + 5;          // GPRs, flags, PC hi/lo, Z hi/lo
    localparam int WSEL_W    = $clog2(CTX_WORDS);
    localparam logic [WSEL_W-1:0] WSEL_FIRST = '0;
    localparam logic [WSEL_W-1:0] WSEL_LAST  = WSEL_W'(CTX_WORDS - 1);

    typedef enum logic [2:0] {
        ST_RUN,       // interrupts enabled, normal execution
        ST_WAIT,      // request accepted, waiting for instruction boundary
        ST_PUSH,      // saving context
        ST_ENTRY_LD,  // vector load after entry
        ST_HANDLER,   // handler running
        ST_CHAIN_LD,  // vector load for a chained request
        ST_POP        // restoring context
    } seq_state_t;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NUM_LINES = 7,
    localparam int NW = $clog2(NUM_LINES + 1)
) (
    input  logic [NUM_LINES:1] req,
    output logic [NW-1:0]      num
);
    always_comb begin
        num = '0;
        for (int i = 1; i <= NUM_LINES; i++) begin
            if (req[i]) num = NW'(i);
        end
    end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int NW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          clear,
    input  logic [NW-1:0] in_num,
    output logic [NW-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst || clear)                      pend <= '0;
        else if (capture && (in_num > pend))   pend <= in_num;
    end

    // pending number never decreases unless explicitly consumed
    AST_PEND_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        (!clear && pend != '0) |=> (pend >= $past(pend)));   // R6
endmodule

// File: rtl/irq_word_ctr.sv
module irq_word_ctr
    import irq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_first,
    input  logic              ld_last,
    input  logic              inc,
    input  logic              dec,
    output logic [WSEL_W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst)           idx <= WSEL_FIRST;
        else if (ld_first) idx <= WSEL_FIRST;
        else if (ld_last)  idx <= WSEL_LAST;
        else if (inc)      idx <= idx + 1'b1;
        else if (dec)      idx <= idx - 1'b1;
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        idx <= WSEL_LAST);   // R2
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int NUM_LINES = 7,
    localparam int NW = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES:1]   irq_req,
    input  logic                 instr_done,
    input  logic                 reti,
    output logic                 ie,
    output logic                 push_req,
    output logic                 pop_req,
    output logic [WSEL_W-1:0]    word_sel,
    output logic                 pc_load,
    output logic                 flags_clr,
    output logic [NW-1:0]        vec_num
);
    seq_state_t        st;
    logic              ie_q;
    logic [NW-1:0]     cur_vec;
    logic [NW-1:0]     req_num;
    logic [NW-1:0]     pend;
    logic [NW-1:0]     merged;
    logic [WSEL_W-1:0] idx;
    logic              pend_cap, pend_clr;
    logic              ld_first, ld_last, c_inc, c_dec;
    logic              chain_go, pop_end, requeue;

    irq_prio_enc #(.NUM_LINES(NUM_LINES)) u_enc (
        .req (irq_req),
        .num (req_num)
    );

    assign merged   = (req_num > pend) ? req_num : pend;
    assign chain_go = (st == ST_HANDLER) && reti && (merged != '0);
    assign pop_end  = (st == ST_POP) && (idx == WSEL_FIRST);
    assign requeue  = pop_end && (merged != '0);

    assign pend_cap = (st != ST_RUN);
    assign pend_clr = (st == ST_RUN) || chain_go || requeue;

    irq_pend_reg #(.NW(NW)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .capture (pend_cap),
        .clear   (pend_clr),
        .in_num  (req_num),
        .pend    (pend)
    );

    assign ld_first = ((st == ST_RUN) && (req_num != '0)) || (st == ST_WAIT);
    assign ld_last  = (st == ST_HANDLER) && reti && (merged == '0);
    assign c_inc    = (st == ST_PUSH) && (idx != WSEL_LAST);
    assign c_dec    = (st == ST_POP) && (idx != WSEL_FIRST);

    irq_word_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .ld_first (ld_first),
        .ld_last  (ld_last),
        .inc      (c_inc),
        .dec      (c_dec),
        .idx      (idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_RUN;
            ie_q    <= 1'b1;
            cur_vec <= '0;
        end else begin
            unique case (st)
                ST_RUN: if (req_num != '0) begin
                    ie_q    <= 1'b0;
                    cur_vec <= req_num;
                    st      <= instr_done ? ST_PUSH : ST_WAIT;
                end
                ST_WAIT: if (instr_done) st <= ST_PUSH;
                ST_PUSH: if (idx == WSEL_LAST) st <= ST_ENTRY_LD;
                ST_ENTRY_LD: st <= ST_HANDLER;
                ST_CHAIN_LD: st <= ST_HANDLER;
                ST_HANDLER: if (reti) begin
                    if (merged != '0) begin
                        cur_vec <= merged;
                        st      <= ST_CHAIN_LD;
                    end else begin
                        st      <= ST_POP;
                    end
                end
                ST_POP: if (idx == WSEL_FIRST) begin
                    if (merged != '0) begin
                        cur_vec <= merged;
                        st      <= ST_WAIT;
                    end else begin
                        ie_q    <= 1'b1;
                        st      <= ST_RUN;
                    end
                end
                default: st <= ST_RUN;
            endcase
        end
    end

    assign ie        = ie_q;
    assign push_req  = (st == ST_PUSH);
    assign pop_req   = (st == ST_POP);
    assign word_sel  = idx;
    assign pc_load   = (st == ST_ENTRY_LD) || (st == ST_CHAIN_LD);
    assign flags_clr = (st == ST_ENTRY_LD);
    assign vec_num   = cur_vec;

    AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (push_req && word_sel != WSEL_LAST) |=> (push_req && word_sel == $past(word_sel) + 1'b1));   // R2
    AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (rst)
        (push_req && word_sel == WSEL_LAST) |=> (pc_load && flags_clr));   // R3
    AST_NO_STACK_IE: assert property (@(posedge clk) disable iff (rst)
        ie |-> (!push_req && !pop_req));   // R4
    AST_POP_ORDER: assert property (@(posedge clk) disable iff (rst)
        (pop_req && word_sel != WSEL_FIRST) |=> (pop_req && word_sel == $past(word_sel) - 1'b1));   // R7
    AST_IE_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
        $rose(ie) |-> ($past(pop_req) && $past(word_sel) == WSEL_FIRST));   // R7
    AST_CHAIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pc_load && !flags_clr) |=> (!push_req && !pop_req));   // R8
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $countones({push_req, pop_req, pc_load}) <= 1);   // R2
endmodule

// File: tb/sim_irq_seq.sv
module sim_irq_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:1] irq_req = '0;
    logic       instr_done = 1'b0;
    logic       reti = 1'b0;
    logic       ie, push_req, pop_req, pc_load, flags_clr;
    logic [3:0] word_sel;
    logic [2:0] vec_num;

    always #2 clk = ~clk;   // 250 MHz

    irq_seq u0 (
        .clk(clk), .rst(rst), .irq_req(irq_req), .instr_done(instr_done),
        .reti(reti), .ie(ie), .push_req(push_req), .pop_req(pop_req),
        .word_sel(word_sel), .pc_load(pc_load), .flags_clr(flags_clr),
        .vec_num(vec_num)
    );

    // kinds: 1 push, 2 pop, 3 entry load, 4 chain load, 5 malformed
    typedef struct {
        int kind; int sel; int vec; int gap; int rq;
    } item_t;
    item_t q[$];

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int last_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void expect_item(int kind, int sel, int vec, int gap, int rq);
        item_t it;
        it.kind = kind; it.sel = sel; it.vec = vec; it.gap = gap; it.rq = rq;
        q.push_back(it);
    endfunction

    // R2 R3: thirteen pushes then entry load
    function automatic void exp_entry(int vec);
        for (int i = 0; i < 13; i++) expect_item(1, i, 0, (i == 0) ? 0 : 1, 2);
        expect_item(3, 0, vec, 1, 3);
    endfunction

    // R7: thirteen pops in reverse
    function automatic void exp_pops();
        for (int i = 12; i >= 0; i--) expect_item(2, i, 0, (i == 12) ? 0 : 1, 7);
    endfunction

    // R8: chained load
    function automatic void exp_chain(int vec);
        expect_item(4, 0, vec, 0, 8);
    endfunction

    task automatic check(bit ok, string rq, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // monitor: compare each observed stack/load event with the scoreboard head
    always @(negedge clk) begin
        if (!rst && (push_req || pop_req || pc_load || flags_clr)) begin
            int k;
            item_t e;
            if (push_req && !pop_req && !pc_load && !flags_clr)      k = 1;
            else if (pop_req && !push_req && !pc_load && !flags_clr) k = 2;
            else if (pc_load && flags_clr && !push_req && !pop_req)  k = 3;
            else if (pc_load && !flags_clr && !push_req && !pop_req) k = 4;
            else                                                     k = 5;
            if (q.size() == 0) begin
                check(1'b0, "unexpected event R1/R4", k, 0);
            end else begin
                e = q.pop_front();
                total++;
                if (k != e.kind ||
                    ((k == 1 || k == 2) && int'(word_sel) != e.sel) ||
                    ((k == 3 || k == 4) && int'(vec_num) != e.vec) ||
                    (e.gap != 0 && (cyc - last_cyc) != e.gap)) begin
                    fails++;
                    $display("FAIL R%0d actual kind=%0d sel=%0d vec=%0d gap=%0d expected kind=%0d sel=%0d vec=%0d gap=%0d",
                             e.rq, k, word_sel, vec_num, cyc - last_cyc, e.kind, e.sel, e.vec, e.gap);
                end
            end
            last_cyc = cyc;
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(logic [7:1] m, bit with_done);
        @(negedge clk);
        irq_req = m; instr_done = with_done;
        @(negedge clk);
        irq_req = '0; instr_done = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); instr_done = 1'b1;
        @(negedge clk); instr_done = 1'b0;
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=%0d expected=0", q.size());
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(1);
        // R10 reset state
        check(ie == 1'b1, "R10 ie", int'(ie), 1);
        check(!push_req && !pop_req && !pc_load && !flags_clr, "R10 strobes",
              int'({push_req, pop_req, pc_load, flags_clr}), 0);

        // R1 R4: request 3, instruction finishes late
        pulse_req(7'b0000100, 1'b0);
        check(ie == 1'b0, "R4 ie after accept", int'(ie), 0);
        cycles(6);   // any push here is flagged by the monitor (R1)
        check(q.size() == 0 && !push_req, "R1 no early push", int'(push_req), 0);
        exp_entry(3);
        pulse_done();
        cycles(16);
        check(q.size() == 0, "R2 entry consumed", q.size(), 0);
        check(ie == 1'b0, "R4 ie in handler", int'(ie), 0);

        // R6: requests 2, 5, 4 in handler -> pending 5; R8 chain
        pulse_req(7'b0000010, 1'b0);
        pulse_req(7'b0010000, 1'b0);
        pulse_req(7'b0001000, 1'b0);
        exp_chain(5);   // R6 highest kept, R8
        pulse_reti();
        cycles(4);
        check(q.size() == 0, "R8 chain load seen", q.size(), 0);
        exp_pops();     // pending cleared by chain -> full restore (R8)
        pulse_reti();
        cycles(16);
        check(q.size() == 0, "R7 pops consumed", q.size(), 0);
        check(ie == 1'b1, "R7 ie restored", int'(ie), 1);

        // R5: lines 6 and 2 together with instr_done
        exp_entry(6);
        pulse_req(7'b0100010, 1'b1);
        cycles(16);
        check(q.size() == 0, "R5 highest served", q.size(), 0);

        // R9: requests during pop are kept
        exp_pops();
        pulse_reti();
        cycles(3);
        pulse_req(7'b0001000, 1'b0);
        pulse_req(7'b0000001, 1'b0);
        cycles(14);
        check(q.size() == 0, "R9 pops done", q.size(), 0);
        check(ie == 1'b0, "R9 ie stays low", int'(ie), 0);
        cycles(3);
        check(!push_req, "R9 waits for done", int'(push_req), 0);
        exp_entry(4);
        pulse_done();
        cycles(16);
        check(q.size() == 0, "R9 re-entry vec4", q.size(), 0);
        exp_pops();
        pulse_reti();
        cycles(16);
        check(ie == 1'b1, "R7 ie after second restore", int'(ie), 1);

        // R9: request during push sequence, then chain to it
        exp_entry(7);
        pulse_req(7'b1000000, 1'b1);
        cycles(4);
        pulse_req(7'b0000100, 1'b0);
        cycles(12);
        check(q.size() == 0, "R9 entry vec7", q.size(), 0);
        exp_chain(3);
        pulse_reti();
        cycles(4);
        exp_pops();
        pulse_reti();
        cycles(16);
        check(q.size() == 0, "R8 all events seen", q.size(), 0);
        check(ie == 1'b1, "R7 final ie", int'(ie), 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule